// File: doc/BRIEF.md
# Interlaced Paired-Bayer Field Sequencer

This block produces the raster timing and per-pixel addressing for an interlaced readout of a colour image array whose Bayer tiling repeats on pairs of rows. Each clock is one pixel slot. The block steps a horizontal counter across active and blanking columns, and a vertical counter across the lines of one field. It alternates between the field that carries the even source rows and the field that carries the odd source rows. For every active slot it reports the source row and column to read, a two-bit colour tag for that site, and whether the line is a dark padding line.

A static pin chooses between the 60 Hz-style and 50 Hz-style field formats. The first format places a few dark lines below the picture. The second places dark lines both above and below it. A second static pin mirrors the readout horizontally. Mirrored readout uses the spare column beyond the image, so the first pixel of every line keeps its colour phase.

Both pins are sampled during reset and again at each field boundary, so a field never changes shape partway through. All outputs are registered. The default geometry is 640 by 480 with a 858-slot line at 13.5 Mpixel/s. This gives about 30 frames per second in the short format and 25 in the tall one.

Top module: `ilace_bayer_seq`

## Requirements
- R1: While `rst` is high every output is 0. The first rising edge with `rst` low shows pixel 0 of line 0 of field 0, so the outputs are registered and lag the internal position by one cycle.
- R2: Each line spans H_ACT+H_BLANK cycles. `line_valid` is high for the first H_ACT of them, but only on lines where `frame_valid` is high.
- R3: With `pal_mode`=0 a field is ROWS/2 image lines, then NTSC_DARK_BOT dark lines, then NTSC_VBLANK lines with `frame_valid` low.
- R4: With `pal_mode`=1 a field is PAL_DARK_TOP dark lines, ROWS/2 image lines, PAL_DARK_BOT dark lines, then PAL_VBLANK lines with `frame_valid` low.
- R5: `field_odd` is 0 for the first field after reset and flips at the first line of each new field, straight after blanking. On image line k, `row_addr` = 2k + `field_odd`.
- R6: Without mirroring, `col_addr` equals the active pixel index 0..H_ACT-1.
- R7: With mirroring, `col_addr` = H_ACT minus the pixel index. It therefore starts at H_ACT, and the first pixel keeps the same colour tag as in normal readout.
- R8: On image pixels `color_tag` = {row_addr[1], col_addr[0]}. The codes are 0 red, 1 green on a red line, 2 green on a blue line, and 3 blue.
- R9: On dark lines `line_valid` and `dark_line` are high, `color_tag` and `row_addr` are 0, and `col_addr` follows R6/R7.
- R10: Whenever `line_valid` is low, `row_addr`, `col_addr`, `color_tag` and `dark_line` are 0.
- R11: Changes on `pal_mode` or `h_mirror` during a field have no effect until the next field begins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| pal_mode | input | 1 | 0: short field format, 1: tall field format |
| h_mirror | input | 1 | 1: horizontal mirrored readout |
| frame_valid | output | 1 | High on every line of the field, dark or image |
| line_valid | output | 1 | High on active pixel slots |
| field_odd | output | 1 | 0: even source rows, 1: odd source rows |
| row_addr | output | $clog2(ROWS) | Source row of the current pixel |
| col_addr | output | $clog2(H_ACT+1) | Source column of the current pixel |
| color_tag | output | 2 | Bayer site code of the current pixel |
| dark_line | output | 1 | High on dark padding pixels |

## Verification
Every output is due exactly one rising edge after the internal position it describes. Pin changes first show up on the line that follows the field boundary, one cycle after the boundary edge. The bench keeps its own position model. At each rising edge it computes the expected outputs from the model's state before advancing it. At the next falling edge it compares them with the ports. The model re-reads the mode pins only when it wraps a field, which matches the field-boundary rule.

// File: rtl/fsq_pkg.sv
package fsq_pkg;

  typedef enum logic [1:0] {
    TAG_R  = 2'd0,
    TAG_GR = 2'd1,
    TAG_GB = 2'd2,
    TAG_B  = 2'd3
  } bayer_tag_e;

  // site colour: row pair parity picks the line type, column parity the site
  function automatic bayer_tag_e site_tag(input logic pair_odd, input logic col_odd);
    return bayer_tag_e'({pair_odd, col_odd});
  endfunction

endpackage

// File: rtl/fsq_line_timer.sv
module fsq_line_timer #(
  parameter int H_ACT   = 640,
  parameter int H_BLANK = 218,
  parameter int HW      = 10
) (
  input  logic          clk,
  input  logic          rst,
  output logic [HW-1:0] hcnt,
  output logic          line_end,
  output logic          h_act
);
  localparam int HT = H_ACT + H_BLANK;

  assign line_end = (hcnt == HW'(HT - 1));
  assign h_act    = (hcnt <  HW'(H_ACT));

  always_ff @(posedge clk) begin
    if (rst)           hcnt <= '0;
    else if (line_end) hcnt <= '0;
    else               hcnt <= hcnt + 1'b1;
  end
endmodule

// File: rtl/fsq_field_seq.sv
module fsq_field_seq #(
  parameter int IMG_LINES     = 240,
  parameter int NTSC_DARK_BOT = 3,
  parameter int NTSC_VBLANK   = 20,
  parameter int PAL_DARK_TOP  = 24,
  parameter int PAL_DARK_BOT  = 24,
  parameter int PAL_VBLANK    = 25,
  parameter int VW            = 9
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          adv,
  input  logic          pal_pin,
  input  logic          mir_pin,
  output logic          in_field,
  output logic          dark,
  output logic [VW-1:0] img_idx,
  output logic          field,
  output logic          mirror
);
  localparam int N_FLD = IMG_LINES + NTSC_DARK_BOT;
  localparam int P_FLD = PAL_DARK_TOP + IMG_LINES + PAL_DARK_BOT;
  localparam int N_TOT = N_FLD + NTSC_VBLANK;
  localparam int P_TOT = P_FLD + PAL_VBLANK;

  logic [VW-1:0] vcnt;
  logic          pal_q;
  logic [VW-1:0] top_n, fld_n, last_n;
  logic          wrap;

  always_comb begin
    top_n  = pal_q ? VW'(PAL_DARK_TOP) : '0;
    fld_n  = pal_q ? VW'(P_FLD)        : VW'(N_FLD);
    last_n = pal_q ? VW'(P_TOT - 1)    : VW'(N_TOT - 1);
  end

  assign wrap     = adv && (vcnt == last_n);
  assign in_field = (vcnt < fld_n);
  assign dark     = in_field && ((vcnt < top_n) || (vcnt >= top_n + VW'(IMG_LINES)));
  assign img_idx  = vcnt - top_n;

  // field shape and mirror are frozen for a whole field
  always_ff @(posedge clk) begin
    if (rst) begin
      vcnt   <= '0;
      field  <= 1'b0;
      pal_q  <= pal_pin;
      mirror <= mir_pin;
    end else if (wrap) begin
      vcnt   <= '0;
      field  <= ~field;
      pal_q  <= pal_pin;
      mirror <= mir_pin;
    end else if (adv) begin
      vcnt   <= vcnt + 1'b1;
    end
  end
endmodule

// File: rtl/fsq_addr_map.sv
module fsq_addr_map #(
  parameter int H_ACT = 640,
  parameter int HW    = 10,
  parameter int VW    = 9,
  parameter int RW    = 9,
  parameter int CW    = 10
) (
  input  logic          h_act,
  input  logic [HW-1:0] hcnt,
  input  logic          in_field,
  input  logic          dark,
  input  logic [VW-1:0] img_idx,
  input  logic          field,
  input  logic          mirror,
  output logic          fv,
  output logic          lv,
  output logic          dk,
  output logic [RW-1:0] row,
  output logic [CW-1:0] col,
  output logic [1:0]    tag
);
  logic [CW-1:0] col_fwd, col_sel;
  logic [RW-1:0] row_img;

  assign col_fwd = CW'(hcnt);
  // mirrored start uses the spare column so column parity is unchanged
  assign col_sel = mirror ? (CW'(H_ACT) - col_fwd) : col_fwd;
  assign row_img = RW'((int'(img_idx) << 1) + int'(field));

  always_comb begin
    fv  = in_field;
    lv  = in_field && h_act;
    dk  = 1'b0;
    row = '0;
    col = '0;
    tag = '0;
    if (lv) begin
      col = col_sel;
      if (dark) begin
        dk = 1'b1;
      end else begin
        row = row_img;
        tag = fsq_pkg::site_tag(row_img[1], col_sel[0]);
      end
    end
  end
endmodule

// File: rtl/ilace_bayer_seq.sv
module ilace_bayer_seq #(
  parameter int H_ACT         = 640,
  parameter int H_BLANK       = 218,
  parameter int ROWS          = 480,
  parameter int NTSC_DARK_BOT = 3,
  parameter int NTSC_VBLANK   = 20,
  parameter int PAL_DARK_TOP  = 24,
  parameter int PAL_DARK_BOT  = 24,
  parameter int PAL_VBLANK    = 25,
  localparam int RW           = $clog2(ROWS),
  localparam int CW           = $clog2(H_ACT + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          pal_mode,
  input  logic          h_mirror,
  output logic          frame_valid,
  output logic          line_valid,
  output logic          field_odd,
  output logic [RW-1:0] row_addr,
  output logic [CW-1:0] col_addr,
  output logic [1:0]    color_tag,
  output logic          dark_line
);
  localparam int IMG_LINES = ROWS / 2;
  localparam int HT        = H_ACT + H_BLANK;
  localparam int HW        = $clog2(HT);
  localparam int N_TOT     = IMG_LINES + NTSC_DARK_BOT + NTSC_VBLANK;
  localparam int P_TOT     = PAL_DARK_TOP + IMG_LINES + PAL_DARK_BOT + PAL_VBLANK;
  localparam int V_MAX     = (N_TOT > P_TOT) ? N_TOT : P_TOT;
  localparam int VW        = $clog2(V_MAX);

  logic [HW-1:0] hcnt;
  logic          line_end, h_act;
  logic          in_field, dark, field, mirror;
  logic [VW-1:0] img_idx;
  logic          fv_n, lv_n, dk_n;
  logic [RW-1:0] row_n;
  logic [CW-1:0] col_n;
  logic [1:0]    tag_n;

  fsq_line_timer #(.H_ACT(H_ACT), .H_BLANK(H_BLANK), .HW(HW)) u_line (
    .clk(clk), .rst(rst), .hcnt(hcnt), .line_end(line_end), .h_act(h_act)
  );

  fsq_field_seq #(
    .IMG_LINES(IMG_LINES), .NTSC_DARK_BOT(NTSC_DARK_BOT), .NTSC_VBLANK(NTSC_VBLANK),
    .PAL_DARK_TOP(PAL_DARK_TOP), .PAL_DARK_BOT(PAL_DARK_BOT), .PAL_VBLANK(PAL_VBLANK),
    .VW(VW)
  ) u_field (
    .clk(clk), .rst(rst), .adv(line_end), .pal_pin(pal_mode), .mir_pin(h_mirror),
    .in_field(in_field), .dark(dark), .img_idx(img_idx), .field(field), .mirror(mirror)
  );

  fsq_addr_map #(.H_ACT(H_ACT), .HW(HW), .VW(VW), .RW(RW), .CW(CW)) u_map (
    .h_act(h_act), .hcnt(hcnt), .in_field(in_field), .dark(dark), .img_idx(img_idx),
    .field(field), .mirror(mirror), .fv(fv_n), .lv(lv_n), .dk(dk_n),
    .row(row_n), .col(col_n), .tag(tag_n)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      frame_valid <= 1'b0;
      line_valid  <= 1'b0;
      field_odd   <= 1'b0;
      row_addr    <= '0;
      col_addr    <= '0;
      color_tag   <= '0;
      dark_line   <= 1'b0;
    end else begin
      frame_valid <= fv_n;
      line_valid  <= lv_n;
      field_odd   <= field;
      row_addr    <= row_n;
      col_addr    <= col_n;
      color_tag   <= tag_n;
      dark_line   <= dk_n;
    end
  end
endmodule

// File: rtl/ilace_bayer_seq_chk.sv
module ilace_bayer_seq_chk #(
  parameter int H_ACT = 640,
  parameter int RW    = 9,
  parameter int CW    = 10
) (
  input logic          clk,
  input logic          rst,
  input logic          frame_valid,
  input logic          line_valid,
  input logic          field_odd,
  input logic [RW-1:0] row_addr,
  input logic [CW-1:0] col_addr,
  input logic [1:0]    color_tag,
  input logic          dark_line
);
  assert_lv_in_fv_R2: assert property (@(posedge clk) disable iff (rst)
    line_valid |-> frame_valid);

  assert_field_flip_R5: assert property (@(posedge clk) disable iff (rst)
    (field_odd != $past(field_odd)) |-> (!$past(frame_valid) && frame_valid));

  assert_col_step_R6: assert property (@(posedge clk) disable iff (rst)
    (line_valid && $past(line_valid)) |->
      ((col_addr == $past(col_addr) + CW'(1)) || (col_addr == $past(col_addr) - CW'(1))));

  assert_col_range_R7: assert property (@(posedge clk) disable iff (rst)
    line_valid |-> (col_addr <= CW'(H_ACT)));

  assert_tag_site_R8: assert property (@(posedge clk) disable iff (rst)
    (line_valid && !dark_line) |-> (color_tag == {row_addr[1], col_addr[0]}));

  assert_dark_pixel_R9: assert property (@(posedge clk) disable iff (rst)
    dark_line |-> (line_valid && color_tag == 2'd0 && row_addr == '0));

  assert_idle_zero_R10: assert property (@(posedge clk) disable iff (rst)
    !line_valid |-> (!dark_line && row_addr == '0 && col_addr == '0 && color_tag == 2'd0));
endmodule

bind ilace_bayer_seq ilace_bayer_seq_chk #(.H_ACT(H_ACT), .RW(RW), .CW(CW)) u_chk (
  .clk(clk), .rst(rst), .frame_valid(frame_valid), .line_valid(line_valid),
  .field_odd(field_odd), .row_addr(row_addr), .col_addr(col_addr),
  .color_tag(color_tag), .dark_line(dark_line)
);

// File: tb/sim_ilace_bayer_seq.sv
module sim_ilace_bayer_seq;
  localparam int HA = 8, HB = 3, ROWS = 8;
  localparam int NB = 1, NV = 2, PTP = 2, PB = 2, PV = 3;
  localparam int IMG = ROWS / 2, HT = HA + HB;

  logic clk = 1'b0, rst = 1'b1, pal_mode = 1'b0, h_mirror = 1'b0;
  logic frame_valid, line_valid, field_odd, dark_line;
  logic [2:0] row_addr;
  logic [3:0] col_addr;
  logic [1:0] color_tag;

  int checks = 0, errors = 0;
  bit done = 0;
  string phase = "";
  int bh, bv, bfield, bmode, bmir;
  int e_fv, e_lv, e_fd, e_row, e_col, e_tag, e_dk;

  always #2 clk = ~clk;

  ilace_bayer_seq #(.H_ACT(HA), .H_BLANK(HB), .ROWS(ROWS), .NTSC_DARK_BOT(NB),
    .NTSC_VBLANK(NV), .PAL_DARK_TOP(PTP), .PAL_DARK_BOT(PB), .PAL_VBLANK(PV)) u0 (
    .clk(clk), .rst(rst), .pal_mode(pal_mode), .h_mirror(h_mirror),
    .frame_valid(frame_valid), .line_valid(line_valid), .field_odd(field_odd),
    .row_addr(row_addr), .col_addr(col_addr), .color_tag(color_tag), .dark_line(dark_line));

  task automatic chk(input string req, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s%s: got %0d expected %0d (h=%0d v=%0d)", req, phase, got, exp, bh, bv);
    end
  endtask

  function automatic int vtot(input int m);
    return m ? (PTP + IMG + PB + PV) : (IMG + NB + NV);
  endfunction

  // expected outputs for the model position
  task automatic predict();
    int top, fld, r;
    top  = bmode ? PTP : 0;
    fld  = top + IMG + (bmode ? PB : NB);
    e_fv = (bv < fld);
    e_lv = e_fv && (bh < HA);
    e_dk = e_lv && ((bv < top) || (bv >= top + IMG));
    e_fd = bfield;
    e_col = e_lv ? (bmir ? HA - bh : bh) : 0;
    r = 2 * (bv - top) + bfield;
    e_row = (e_lv && !e_dk) ? r : 0;
    e_tag = (e_lv && !e_dk) ? (((r / 2) % 2) * 2 + (e_col % 2)) : 0;
  endtask

  task automatic advance();
    if (bh == HT - 1) begin
      bh = 0;
      if (bv == vtot(bmode) - 1) begin
        bv = 0; bfield ^= 1; bmode = pal_mode; bmir = h_mirror;
      end else bv++;
    end else bh++;
  endtask

  task automatic run(input bit m, input bit mir, input int cycles, input bit wiggle);
    @(negedge clk);
    rst = 1'b1; pal_mode = m; h_mirror = mir;
    repeat (3) @(negedge clk);
    chk("R1", {frame_valid, line_valid, field_odd, dark_line}, 0);
    chk("R1", row_addr + col_addr + color_tag, 0);
    rst = 1'b0;
    bh = 0; bv = 0; bfield = 0; bmode = m; bmir = mir;
    for (int n = 0; n < cycles; n++) begin
      @(posedge clk);
      predict();
      advance();
      @(negedge clk);
      chk(e_fd == 0 && e_fv == 0 && n == 0 ? "R1" : (bmode ? "R4" : "R3"), frame_valid, e_fv);
      chk("R2", line_valid, e_lv);
      chk("R5", field_odd, e_fd);
      chk(e_dk ? "R9" : "R5", row_addr, e_row);
      chk(e_lv ? (bmir ? "R7" : "R6") : "R10", col_addr, e_col);
      chk(e_lv ? "R8" : "R10", color_tag, e_tag);
      chk("R9", dark_line, e_dk);
      if (wiggle && ($urandom % 23 == 0)) pal_mode = ~pal_mode;
      if (wiggle && ($urandom % 29 == 0)) h_mirror = ~h_mirror;
    end
  endtask

  initial begin
    void'($urandom(32'd1234));
    run(1'b0, 1'b0, 400, 1'b0);
    run(1'b0, 1'b1, 400, 1'b0);
    run(1'b1, 1'b0, 520, 1'b0);
    run(1'b1, 1'b1, 520, 1'b0);
    // directed: mirrored first pixel keeps the red phase (R7)
    @(negedge clk); rst = 1'b1; h_mirror = 1'b1; pal_mode = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R7", col_addr, HA);
    chk("R7", color_tag, 0);
    phase = " R11";
    run(1'b0, 1'b0, 900, 1'b1);
    run(1'b1, 1'b1, 900, 1'b1);
    phase = "";
    for (int k = 0; k < 6; k++)
      run(1'($urandom % 2), 1'($urandom % 2), 200 + int'($urandom % 300), 1'($urandom % 2));
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule